// File: doc/BRIEF.md
# Dual-Enable Synchronous Counter with Carry-Triggered Reload

This block is a synchronous binary up-counter built from 4-bit digit stages. Each stage has a synchronous clear, a synchronous parallel load, two count enables that must both be high for the stage to advance, and a carry output. The carry is high while the stage holds all ones and its second enable is high. Stages are chained inside the block: each stage's second enable is driven by the carry of the stage below it. The chain therefore acts as one binary counter of `STAGES * DIGIT_W` bits, and its top carry is available for cascading further.

When the `SELF_RELOAD` parameter is set, the chain's own carry drives the load path with a fixed `START_VAL`. The counter then runs from `START_VAL` up to all ones and returns to `START_VAL`, which gives an offset counter of `2^W - START_VAL` states. For one stage with a start value of 6, that is ten states, 6 through 15. Control priority is fixed:
- synchronous reset,
- then active-low clear,
- then active-low load (the external load comes before the carry-driven reload),
- then count,
- then hold.

Top module: `sync_offset_counter`

## Requirements
- R1: With `rst` high at a rising edge, `count` becomes 0 at that edge.
- R2: With `rst` low and `clear_n` low at a rising edge, `count` becomes 0, whatever the load, enable and carry inputs are.
- R3: With `clear_n` high and `load_n` low at a rising edge, `count` takes `load_val`, whatever the enables and the carry are.
- R4: With `clear_n` and `load_n` high, no reload pending, and both `en_p` and `en_t` high, `count` increases by one at the edge and wraps from all ones to 0.
- R5: With `clear_n` and `load_n` high, no reload pending, and `en_p` or `en_t` low, `count` keeps its value.
- R6: `carry` is high in the same cycle exactly when `count` is all ones and `en_t` is high. It follows `en_t` combinationally.
- R7: In a multi-stage chain, a stage advances only when every lower stage is all ones, so the full count steps through 0x0F to 0x10 and 0xFF to 0x00 as one binary value.
- R8: With `SELF_RELOAD` set, `clear_n` and `load_n` high, and `carry` high, `count` takes `START_VAL` at the next edge, even when `en_p` is low.
- R9: With `SELF_RELOAD` set, one stage and `START_VAL` of 6, both enables high, and the counter loaded with 6, `count` repeats 6, 7, ..., 15, 6: ten states per period.
- R10: When the carry-driven reload and an external load (`load_n` low) fall in the same cycle, `load_val` is taken. When clear also falls in that cycle, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| load_val | input | STAGES*DIGIT_W | Parallel load value |
| count | output | STAGES*DIGIT_W | Current count |
| carry | output | 1 | Terminal-state carry of the whole chain |

## Verification
The carry-driven reload can coincide with an external load or a clear, because the carry rises whenever the counter sits at all ones with `en_t` high. The bench parks the offset counter at 15, then asserts `load_n` with a different value in one run and `clear_n` in another. It expects `load_val` in the first case and 0 in the second, never the start value. Random stimulus also drives the enables low at the terminal state, and there a reload must still occur when `en_p` alone is low and must not occur when `en_t` is low.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic clear_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctr_ctl_t;

    // Fixed priority: clear, load, count, hold
    function automatic ctr_op_e pick_op(ctr_ctl_t c);
        if (!c.clear_n)           return OP_CLEAR;
        else if (!c.load_n)       return OP_LOAD;
        else if (c.en_p && c.en_t) return OP_COUNT;
        else                      return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_op_decode.sv
`timescale 1ns/1ps
module ctr_op_decode
    import ctr_pkg::*;
(
    input  ctr_ctl_t ctl,
    output ctr_op_e  op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/ctr_digit.sv
`timescale 1ns/1ps
module ctr_digit
    import ctr_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  ctr_op_e      op,
    input  logic [W-1:0] d,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= d;
                OP_COUNT: q <= q + ONE;
                default:  q <= q;
            endcase
        end
    end

    assign carry = en_t & (&q);

    // R4
    digit_step_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_COUNT |=> q == $past(q) + ONE);

    // R5
    digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(q));
endmodule

// File: rtl/ctr_reload_gate.sv
`timescale 1ns/1ps
module ctr_reload_gate #(
    parameter int unsigned   TOT_W       = 8,
    parameter bit            SELF_RELOAD = 1'b0,
    parameter logic [TOT_W-1:0] START_V  = '0
) (
    input  logic             load_n_ext,
    input  logic             chain_carry,
    input  logic [TOT_W-1:0] load_val,
    output logic             load_n_eff,
    output logic [TOT_W-1:0] load_d_eff
);
    generate
        if (SELF_RELOAD) begin : g_reload
            // External load wins over the carry-driven reload
            assign load_n_eff = load_n_ext & ~chain_carry;
            assign load_d_eff = load_n_ext ? START_V : load_val;
        end else begin : g_plain
            logic unused_carry;
            assign unused_carry = chain_carry;
            assign load_n_eff   = load_n_ext;
            assign load_d_eff   = load_val;
        end
    endgenerate
endmodule

// File: rtl/sync_offset_counter.sv
`timescale 1ns/1ps
module sync_offset_counter
    import ctr_pkg::*;
#(
    parameter int unsigned DIGIT_W     = 4,
    parameter int unsigned STAGES      = 2,
    parameter bit          SELF_RELOAD = 1'b0,
    parameter int unsigned START_VAL   = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear_n,
    input  logic                        load_n,
    input  logic                        en_p,
    input  logic                        en_t,
    input  logic [STAGES*DIGIT_W-1:0]   load_val,
    output logic [STAGES*DIGIT_W-1:0]   count,
    output logic                        carry
);
    localparam int unsigned       TOT_W   = STAGES * DIGIT_W;
    localparam logic [TOT_W-1:0]  START_V = TOT_W'(START_VAL);
    localparam logic [TOT_W-1:0]  ALL1    = '1;
    localparam logic [TOT_W-1:0]  ONE     = TOT_W'(1);

    logic [STAGES-1:0] stage_carry;
    logic              load_n_eff;
    logic [TOT_W-1:0]  load_d_eff;

    ctr_reload_gate #(
        .TOT_W       (TOT_W),
        .SELF_RELOAD (SELF_RELOAD),
        .START_V     (START_V)
    ) u_reload (
        .load_n_ext  (load_n),
        .chain_carry (carry),
        .load_val    (load_val),
        .load_n_eff  (load_n_eff),
        .load_d_eff  (load_d_eff)
    );

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic     en_t_s;
            ctr_ctl_t ctl_s;
            ctr_op_e  op_s;

            if (s == 0) begin : g_first
                assign en_t_s = en_t;
            end else begin : g_chain
                assign en_t_s = stage_carry[s-1];
            end

            assign ctl_s = '{clear_n: clear_n, load_n: load_n_eff,
                             en_p: en_p, en_t: en_t_s};

            ctr_op_decode u_dec (
                .ctl (ctl_s),
                .op  (op_s)
            );

            ctr_digit #(.W(DIGIT_W)) u_digit (
                .clk   (clk),
                .rst   (rst),
                .op    (op_s),
                .d     (load_d_eff[s*DIGIT_W +: DIGIT_W]),
                .en_t  (en_t_s),
                .q     (count[s*DIGIT_W +: DIGIT_W]),
                .carry (stage_carry[s])
            );
        end
    endgenerate

    assign carry = stage_carry[STAGES-1];

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> count == '0);

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> count == '0);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        clear_n && !load_n |=> count == $past(load_val));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        clear_n && load_n && en_p && en_t && !(SELF_RELOAD && carry)
        |=> count == $past(count) + ONE);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        clear_n && load_n && !(en_p && en_t) && !(SELF_RELOAD && carry)
        |=> $stable(count));

    // R6
    carry_term_chk: assert property (@(posedge clk) disable iff (rst)
        carry |-> (count == ALL1) && en_t);

    // R8
    reload_start_chk: assert property (@(posedge clk) disable iff (rst)
        SELF_RELOAD && clear_n && load_n && carry |=> count == START_V);
endmodule

// File: tb/tb_sync_offset_counter.sv
`timescale 1ns/1ps
module tb_sync_offset_counter;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       a_clr = 1'b1, a_ld = 1'b1, a_ep = 1'b0, a_et = 1'b0;
    logic [7:0] a_lv = '0, a_cnt;
    logic       a_cy;
    logic       b_clr = 1'b1, b_ld = 1'b1, b_ep = 1'b0, b_et = 1'b0;
    logic [3:0] b_lv = '0, b_cnt;
    logic       b_cy;

    sync_offset_counter #(.DIGIT_W(4), .STAGES(2), .SELF_RELOAD(1'b0), .START_VAL(0)) dut (
        .clk(clk), .rst(rst), .clear_n(a_clr), .load_n(a_ld), .en_p(a_ep), .en_t(a_et),
        .load_val(a_lv), .count(a_cnt), .carry(a_cy));

    sync_offset_counter #(.DIGIT_W(4), .STAGES(1), .SELF_RELOAD(1'b1), .START_VAL(6)) dut_ofs (
        .clk(clk), .rst(rst), .clear_n(b_clr), .load_n(b_ld), .en_p(b_ep), .en_t(b_et),
        .load_val(b_lv), .count(b_cnt), .carry(b_cy));

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    logic [7:0] ea = '0;
    logic [3:0] eb = '0;
    string ta = "R1", tb = "R1";

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference: 8-bit chain, no reload (R1-R5, R7)
    function automatic logic [7:0] nxt_a(logic [7:0] c);
        if (rst) return 8'h00;
        if (!a_clr) return 8'h00;
        if (!a_ld) return a_lv;
        if (a_ep && a_et) return c + 8'h01;
        return c;
    endfunction

    // Reference: 4-bit offset counter, start 6 (R8, R10)
    function automatic logic [3:0] nxt_b(logic [3:0] c);
        if (rst) return 4'h0;
        if (!b_clr) return 4'h0;
        if (!b_ld) return b_lv;
        if (c == 4'hF && b_et) return 4'h6;
        if (b_ep && b_et) return c + 4'h1;
        return c;
    endfunction

    always @(posedge clk) begin
        ea <= nxt_a(ea);
        eb <= nxt_b(eb);
        ta <= rst ? "R1" : !a_clr ? "R2" : !a_ld ? "R3" : (a_ep && a_et) ? "R4/R7" : "R5";
        tb <= rst ? "R1" : !b_clr ? "R2/R10" : !b_ld ? "R3/R10" :
              (eb == 4'hF && b_et) ? "R8" : (b_ep && b_et) ? "R4" : "R5";
    end

    always @(negedge clk) begin
        if (chk_on) begin
            #2;
            chk(ta, a_cnt, ea);
            chk({tb, "_ofs"}, {4'h0, b_cnt}, {4'h0, eb});
            chk("R6_R7 carry", {7'h0, a_cy}, {7'h0, (ea == 8'hFF) && a_et});
            chk("R6 carry_ofs", {7'h0, b_cy}, {7'h0, (eb == 4'hF) && b_et});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        #2;
        chk("R1 reset", a_cnt, 8'h00);
        chk("R1 reset_ofs", {4'h0, b_cnt}, 8'h00);
        rst = 1'b0;
        chk_on = 1'b1;

        // R7: nibble carry into upper stage
        a_ld = 1'b0; a_lv = 8'h0D; tick();
        a_ld = 1'b1; a_ep = 1'b1; a_et = 1'b1; repeat (5) tick();
        // R4: wrap from all ones
        a_ld = 1'b0; a_lv = 8'hFE; tick();
        a_ld = 1'b1; repeat (3) tick();
        // R6 / R5: terminal state with en_t low holds and gives no carry
        a_ld = 1'b0; a_lv = 8'hFF; tick();
        a_ld = 1'b1; a_et = 1'b0; repeat (2) tick();
        a_et = 1'b1; a_ep = 1'b0; repeat (2) tick();
        // R2: clear beats load and count
        a_ep = 1'b1; a_clr = 1'b0; a_ld = 1'b0; a_lv = 8'h55; tick();
        // R3: load beats count
        a_clr = 1'b1; a_lv = 8'hA5; tick();
        a_ld = 1'b1; tick();

        // R9: offset sequence of ten states
        b_ld = 1'b0; b_lv = 4'h6; tick();
        b_ld = 1'b1; b_ep = 1'b1; b_et = 1'b1;
        for (int i = 0; i < 21; i++) begin
            #3;
            chk("R9 offset sequence", {4'h0, b_cnt}, 8'(6 + (i % 10)));
            tick();
        end
        // R8: reload with en_p low at terminal state
        b_ld = 1'b0; b_lv = 4'hF; tick();
        b_ld = 1'b1; b_ep = 1'b0; tick();
        #3; chk("R8 reload without en_p", {4'h0, b_cnt}, 8'h06);
        tick();
        // R10: external load wins over reload
        b_ld = 1'b0; b_lv = 4'hF; tick();
        b_lv = 4'h3; b_et = 1'b1; tick();
        #3; chk("R10 load over reload", {4'h0, b_cnt}, 8'h03);
        tick();
        // R10: clear wins over reload
        b_lv = 4'hF; tick();
        b_ld = 1'b1; b_clr = 1'b0; tick();
        #3; chk("R10 clear over reload", {4'h0, b_cnt}, 8'h00);
        b_clr = 1'b1; tick();

        // Constrained random on both instances
        for (int k = 0; k < 4000; k++) begin
            rst   = ($urandom % 300) == 0;
            a_clr = ($urandom % 20) != 0;
            a_ld  = ($urandom % 12) != 0;
            a_ep  = ($urandom % 5) != 0;
            a_et  = ($urandom % 5) != 0;
            a_lv  = ($urandom % 2) ? 8'(8'hF0 | ($urandom % 16)) : 8'($urandom);
            b_clr = ($urandom % 20) != 0;
            b_ld  = ($urandom % 12) != 0;
            b_ep  = ($urandom % 4) != 0;
            b_et  = ($urandom % 4) != 0;
            b_lv  = 4'($urandom);
            tick();
        end
        rst = 1'b0;
        tick();
        chk_on = 1'b0;
        #3;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule